// File: doc/BRIEF.md
# Automatic Status Polling Matcher

The block keeps asking a serial read engine for a flash status value and checks every answer against a target until a condition is met. Each answer carries one to four status bytes. A 32-bit mask picks the bits that count, a 32-bit value gives their wanted levels, and one select bit decides whether all of those bits must agree (AND) or whether a single agreeing bit is enough (OR). Between two reads the block stays silent for a programmable number of clock cycles.

Polling begins with a one-cycle start strobe. When automatic stop is on, the first match ends the run. When it is off, the block keeps reading, setting the sticky match flag on every hit, until an abort arrives. Every end of a run gives a one-cycle completion pulse and drops busy. The read engine is reached through a plain request/acknowledge pair. Building the serial frames of the read itself is handled outside this block.

Top module: `status_poll_matcher`

## Requirements
- R1: After reset, busy, rd_req, done and match_flag are all 0.
- R2: A start pulse while idle (and abort low) makes busy and rd_req 1 from the next cycle. A start pulse while busy has no effect.
- R3: cfg_size holds the byte count minus one (0 = one byte … 3 = four bytes). The status value is taken from the low bytes of rd_data, with byte 0 at bits 7:0. Bits of rd_data, cfg_mask and cfg_value above that size play no part in the comparison.
- R4: With cfg_or_mode = 0, a response matches when every bit selected by the effective mask equals the matching bit of cfg_value. An effective mask of zero always matches.
- R5: With cfg_or_mode = 1, a response matches when at least one selected bit equals its cfg_value bit. An effective mask of zero never matches.
- R6: After an accepted response that does not end the run, rd_req stays low for exactly cfg_gap cycles (0 to 65535) before the next request. With cfg_gap = 0, rd_req stays high and the next request starts in the following cycle.
- R7: Once raised, rd_req stays high until a cycle with rd_ack high (or an abort).
- R8: With cfg_auto_stop = 1, the first matching response ends the run: busy falls and done is high for exactly one cycle, both from the clock edge that accepted the response.
- R9: With cfg_auto_stop = 0, matches do not end the run, and polling goes on until an abort.
- R10: Abort while busy ends the run at the next edge with a done pulse, and a response accepted in that same cycle is discarded. Abort while idle has no effect and gives no done pulse.
- R11: An accepted matching response sets match_flag, which then stays set until flag_clr. A match and a flag_clr in the same cycle leave the flag set, and every later match sets it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a polling run |
| abort | input | 1 | Ends a running poll |
| cfg_mask | input | 32 | Selects the bits that take part in the comparison |
| cfg_value | input | 32 | Wanted levels of the selected bits |
| cfg_or_mode | input | 1 | 0 = all selected bits must agree, 1 = any selected bit agreeing is enough |
| cfg_auto_stop | input | 1 | 1 = stop on the first match |
| cfg_size | input | 2 | Number of status bytes minus one |
| cfg_gap | input | 16 | Idle cycles between reads |
| rd_req | output | 1 | Asks the read engine for a status value |
| rd_ack | input | 1 | Read engine answer valid; accepted while rd_req is high |
| rd_data | input | 32 | Status bytes returned, byte 0 in bits 7:0 |
| busy | output | 1 | A polling run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| match_flag | output | 1 | Sticky status-match flag |
| flag_clr | input | 1 | Clears match_flag |

## Verification
The assertions assume that the configuration inputs stay constant while busy is high. They also assume that the read engine raises rd_ack only while rd_req is high, and that start, abort and flag_clr are driven as single-cycle or short pulses that are synchronous to the clock. The bench sets the configuration only between runs. Its responder answers a request only when it sees rd_req high, and it can hold back the answer for several cycles to exercise the waiting request. Aborts and flag clears are placed both inside gap windows and during back-to-back reads, so the properties are tested in the same cycle as accepted responses and also away from them.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_READ = 2'd1,
        PS_WAIT = 2'd2
    } poll_state_e;

    typedef struct packed {
        poll_state_e nxt;
        logic        finish;
        logic        load_gap;
        logic        take;
    } poll_step_t;

    function automatic int size_bits(input int nbytes);
        return (nbytes > 1) ? $clog2(nbytes) : 1;
    endfunction

endpackage

// File: rtl/poll_cmp.sv
module poll_cmp #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] value,
    input  logic              or_mode,
    input  logic [SIZE_W-1:0] size,
    output logic              hit
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] lane_keep;
    logic [DATA_W-1:0] eff_mask;
    logic [DATA_W-1:0] agree;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_keep[g*8 +: 8] = {8{(g <= int'(size))}};
    end

    assign eff_mask = mask & lane_keep;
    assign agree    = ~(data ^ value) & eff_mask;
    assign hit      = or_mode ? (|agree) : (agree == eff_mask);
endmodule

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [GAP_W-1:0] len,
    output logic             expire
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == GAP_W'(1));
endmodule

// File: rtl/poll_flag.sv
module poll_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= set | (flag & ~clr);
        end
    end
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher
    import poll_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int GAP_W  = 16,
    localparam int NBYTES = DATA_W / 8,
    localparam int SIZE_W = size_bits(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] cfg_value,
    input  logic              cfg_or_mode,
    input  logic              cfg_auto_stop,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              match_flag,
    input  logic              flag_clr
);
    poll_state_e st;
    poll_step_t  step;
    logic        hit;
    logic        gap_expire;
    logic        done_q;

    poll_cmp #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_cmp (
        .data    (rd_data),
        .mask    (cfg_mask),
        .value   (cfg_value),
        .or_mode (cfg_or_mode),
        .size    (cfg_size),
        .hit     (hit)
    );

    poll_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .clr    (abort),
        .load   (step.load_gap),
        .len    (cfg_gap),
        .expire (gap_expire)
    );

    poll_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (step.take & hit),
        .clr  (flag_clr),
        .flag (match_flag)
    );

    // Next-step decision: abort outranks a response in the same cycle.
    always_comb begin
        step          = '0;
        step.nxt      = st;
        unique case (st)
            PS_IDLE: begin
                if (start && !abort) step.nxt = PS_READ;
            end
            PS_READ: begin
                if (abort) begin
                    step.nxt    = PS_IDLE;
                    step.finish = 1'b1;
                end else if (rd_ack) begin
                    step.take = 1'b1;
                    if (hit && cfg_auto_stop) begin
                        step.nxt    = PS_IDLE;
                        step.finish = 1'b1;
                    end else if (cfg_gap != '0) begin
                        step.nxt      = PS_WAIT;
                        step.load_gap = 1'b1;
                    end
                end
            end
            PS_WAIT: begin
                if (abort) begin
                    step.nxt    = PS_IDLE;
                    step.finish = 1'b1;
                end else if (gap_expire) begin
                    step.nxt = PS_READ;
                end
            end
            default: step.nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PS_IDLE;
            done_q <= 1'b0;
        end else begin
            st     <= step.nxt;
            done_q <= step.finish;
        end
    end

    assign rd_req = (st == PS_READ);
    assign busy   = (st != PS_IDLE);
    assign done   = done_q;
endmodule

// File: rtl/status_poll_matcher_chk.sv
module status_poll_matcher_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic abort,
    input logic rd_req,
    input logic rd_ack,
    input logic busy,
    input logic done,
    input logic match_flag,
    input logic flag_clr
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !rd_req && !done && !match_flag)) else $error("reset state"); // R1

    AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !abort) |=> (busy && rd_req)) else $error("start"); // R2

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy) else $error("req without busy"); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack && !abort) |=> rd_req) else $error("request dropped"); // R7

    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done) else $error("end without done"); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && abort) |=> (!busy && done)) else $error("abort"); // R10

    AST_IDLE_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !done) else $error("done from idle"); // R10

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(match_flag) |-> $past(rd_req && rd_ack && !abort)) else $error("flag source"); // R11

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !(rd_req && rd_ack)) |=> !match_flag) else $error("flag clear"); // R11
endmodule

bind status_poll_matcher status_poll_matcher_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .abort      (abort),
    .rd_req     (rd_req),
    .rd_ack     (rd_ack),
    .busy       (busy),
    .done       (done),
    .match_flag (match_flag),
    .flag_clr   (flag_clr)
);

// File: tb/sim_status_poll_matcher.sv
module sim_status_poll_matcher;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, abort = 1'b0, flag_clr = 1'b0;
    logic [31:0] cfg_mask = '0, cfg_value = '0;
    logic        cfg_or_mode = 1'b0, cfg_auto_stop = 1'b1;
    logic [1:0]  cfg_size = '0;
    logic [15:0] cfg_gap = '0;
    logic        rd_req, rd_ack = 1'b0, busy, done, match_flag;
    logic [31:0] rd_data = '0;

    int total = 0, bad = 0;
    bit ended = 0;

    typedef struct { int reads; int lows; bit flag; } exp_t;
    exp_t        exp_q[$];
    logic [31:0] rsp_q[$];
    logic [31:0] last_rsp = '0;
    int          rsp_delay = 0, rsp_wait = 0;
    int          acc = 0, lows = 0;
    logic        prev_busy = 1'b0, prev_req = 1'b0;

    always #10 clk = ~clk;

    status_poll_matcher u0 (
        .clk(clk), .rst(rst), .start(start), .abort(abort),
        .cfg_mask(cfg_mask), .cfg_value(cfg_value), .cfg_or_mode(cfg_or_mode),
        .cfg_auto_stop(cfg_auto_stop), .cfg_size(cfg_size), .cfg_gap(cfg_gap),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
        .busy(busy), .done(done), .match_flag(match_flag), .flag_clr(flag_clr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor and responder: sample first, then drive the next answer.
    always @(negedge clk) begin
        bit taken;
        if (!rst) begin
            if (busy && !prev_busy) begin acc = 0; lows = 0; end
            taken = rd_ack && !abort;
            if (taken) acc++;
            if (busy && !rd_req) lows++;
            if (prev_req && !taken && !abort && !done) begin
                check(rd_req, "R7 request held", rd_req, 1);
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(!busy, "R8 busy low at done", busy, 0);
                    if (e.reads >= 0) check(acc == e.reads, "R8 read count", acc, e.reads);
                    if (e.lows >= 0) check(lows == e.lows, "R6 gap cycles", lows, e.lows);
                    check(match_flag == e.flag, "R11 flag at end", match_flag, e.flag);
                end
            end
        end
        prev_busy = busy;
        prev_req  = rd_req;
        rd_ack = 1'b0;
        if (rd_req && !rst) begin
            if (rsp_wait < rsp_delay) begin
                rsp_wait++;
            end else begin
                rsp_wait = 0;
                rd_ack = 1'b1;
                if (rsp_q.size() != 0) last_rsp = rsp_q.pop_front();
                rd_data = last_rsp;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic setup(input logic [31:0] m, input logic [31:0] v, input logic orm,
                         input logic ast, input logic [1:0] sz, input logic [15:0] gp);
        cfg_mask = m; cfg_value = v; cfg_or_mode = orm;
        cfg_auto_stop = ast; cfg_size = sz; cfg_gap = gp;
    endtask

    task automatic kick(input int reads, input int lw, input bit fl);
        exp_t e;
        e.reads = reads; e.lows = lw; e.flag = fl;
        exp_q.push_back(e);
        start = 1'b1;
        cyc(1);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin cyc(1); n++; end
        check(!busy, "R8 run ended", busy, 0);
        cyc(2);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    task automatic do_abort();
        abort = 1'b1; cyc(1); abort = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            check(0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check(!busy && !rd_req && !done && !match_flag, "R1 reset state",
              {busy, rd_req, done, match_flag}, 0);

        // AND mode, gap 3, stop on third read; a stray start during the gap
        setup(32'h81, 32'h80, 0, 1, 0, 16'd3);
        rsp_q = '{32'h01, 32'h03, 32'h80};
        kick(3, 6, 1);
        check(busy && rd_req, "R2 start opens poll", {busy, rd_req}, 2'b11);
        cyc(2);
        start = 1'b1; cyc(1); start = 1'b0;   // R2 ignored while busy
        wait_idle();

        pulse_clr();
        check(!match_flag, "R11 flag cleared", match_flag, 0);

        // OR mode: 0x05 vs 0x0A agrees nowhere, 0x04 agrees at bit 0
        setup(32'h0F, 32'h0A, 1, 1, 1, 16'd0);
        rsp_q = '{32'h05, 32'h04};
        kick(2, 0, 1);
        wait_idle();
        pulse_clr();

        // R3: one byte, upper bits of data, mask and value ignored
        setup(32'hFFFF_FFFF, 32'h1234_5655, 0, 1, 0, 16'd0);
        rsp_q = '{32'hFFFF_FF55};
        kick(1, 0, 1);
        wait_idle();
        pulse_clr();

        // R3: four bytes, full width counts; gap 1; slow responder for R7
        setup(32'hFFFF_FFFF, 32'h1234_5655, 0, 1, 3, 16'd1);
        rsp_delay = 3;
        rsp_q = '{32'h1234_5654, 32'h1234_5655};
        kick(2, 1, 1);
        wait_idle();
        rsp_delay = 0;
        pulse_clr();

        // R4: zero mask in AND mode matches the first read
        setup(32'h0, 32'hDEAD_BEEF, 0, 1, 3, 16'd5);
        rsp_q = '{32'h0000_1111};
        kick(1, 0, 1);
        wait_idle();
        pulse_clr();

        // R5: OR mode with effective mask zero never matches, end by abort
        setup(32'hFFFF_FF00, 32'h0, 1, 1, 0, 16'd2);
        rsp_q = '{32'h0};
        kick(-1, -1, 0);
        cyc(20);
        check(busy && !match_flag, "R5 no match with empty mask", {busy, match_flag}, 2'b10);
        do_abort();                            // R10
        wait_idle();

        // R9/R11: continuous polling, clear in gap, flag sets again
        setup(32'h0, 32'h0, 0, 0, 0, 16'd20);
        kick(-1, -1, 1);
        cyc(3);
        check(match_flag && busy, "R9 keeps polling after match", {match_flag, busy}, 2'b11);
        pulse_clr();
        check(!match_flag, "R11 clear while polling", match_flag, 0);
        cyc(25);
        check(match_flag && busy, "R11 flag set again", {match_flag, busy}, 2'b11);
        do_abort();
        wait_idle();
        cyc(5);
        check(!busy && !rd_req, "R10 stays idle after abort", {busy, rd_req}, 0);

        // R11: set and clear together with back-to-back reads
        setup(32'h0, 32'h0, 0, 0, 0, 16'd0);
        kick(-1, 0, 1);
        cyc(4);
        pulse_clr();
        check(match_flag, "R11 set wins over clear", match_flag, 1);
        check(rd_req, "R6 zero gap keeps request high", rd_req, 1);
        do_abort();
        wait_idle();
        pulse_clr();

        // R10: abort while idle gives no done
        abort = 1'b1; cyc(1); abort = 1'b0;
        check(!done && !busy, "R10 idle abort ignored", {done, busy}, 0);
        cyc(1);
        check(!done, "R10 idle abort no pulse", done, 0);
        check(exp_q.size() == 0, "R8 all runs completed", exp_q.size(), 0);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule